// File: doc/BRIEF.md
# Posted Interrupt Controller with Vectoring

This block gathers eight hardware interrupt sources into per-source posted flags and hands the CPU a single pending request together with an 8-bit vector. Software uses a small register bus to read the posted flags, clear them one by one, post them by software, and mask each source. A request is raised only while at least one posted flag is unmasked and the CPU's global interrupt enable input is high. The lowest-numbered pending source wins. Its vector points into a table whose entries are four bytes apart, so each entry can hold a long jump.

Two sources are GPIO ports, which post on a rising edge of their level input. The other six post on any cycle in which their event input is high. When the CPU acknowledges a request, the flag of the source being vectored is cleared. The request/acknowledge pair behaves like a valid/ready handshake. `irq_req` is the valid and `irq_ack` the ready, and a transfer happens on a clock edge where both are high. There is no back-pressure on the sources: an event that arrives while a flag is already set merges into that flag.

Top module: `pic_vector_ctrl`

## Requirements
- R1: After reset, the flag register (address 0), the mask register (address 1) and the control register (address 2) all read 0, and `irq_req` is low.
- R2: Reading address 0 returns 1 in bit i exactly when source i has a posted flag. The bit order is: 0 power-on/low-voltage, 1 external line A, 2 SPI transmit, 3 SPI receive, 4 GPIO port 0, 5 external line B, 6 sleep timer, 7 GPIO port 1.
- R3: Writing 0 to bit i of address 0 clears posted flag i on that clock edge.
- R4: Writing 1 to bit i of address 0 posts flag i only while the software-post enable (bit 7 of address 2) is 1. Otherwise the 1 leaves flag i unchanged.
- R5: Sources 4 and 7 post only on a 0-to-1 transition of their input. A level held high does not post again after the flag has been cleared.
- R6: Sources 0, 1, 2, 3, 5 and 6 post flag i on every clock edge at which their input is 1.
- R7: `irq_req` is high exactly when `gie` is 1 and some posted flag has its mask bit (address 1, bit i) set. This includes the cycle right after a mask write unmasks a source that is already posted, and the same cycle in which `gie` rises while something is pending.
- R8: When several unmasked flags are posted, the lowest index i is vectored. `irq_vec` equals 0x04 + 4*i while `irq_req` is high, and 0 otherwise.
- R9: A clock edge with both `irq_req` and `irq_ack` high clears the flag of the vectored source, unless a hardware event for that source arrives on the same edge, in which case the flag stays set.
- R10: If a hardware event for source i arrives on the same edge as a clear write or a software post to bit i, flag i ends up set.
- R11: Address 1 reads back the last value written. Address 2 reads back the software-post enable in bit 7 and 0 in bits 6..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 8 | Hardware source inputs: event strobes, or GPIO levels on bits 4 and 7 |
| reg_addr | input | 2 | Register select: 0 flags, 1 mask, 2 control |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| gie | input | 1 | Global interrupt enable from the CPU |
| irq_req | output | 1 | Request valid |
| irq_ack | input | 1 | Acknowledge; acts as ready for the request |
| irq_vec | output | 8 | Vector of the highest-priority pending source |

## Verification
The assertions assume that `src_in`, `gie`, `irq_ack` and the register bus are synchronous to `clk`. There is no synchroniser in front of the edge detector, so an asynchronous GPIO level would break the rule that an edge-detect output never stays high for two cycles in a row. The assertions also assume `irq_ack` is only meaningful while `irq_req` is high. The bench changes every input on the falling edge, keeps the GPIO lines low through reset, and raises `irq_ack` only while a request is visible. Same-edge races are created by changing an event input and a bus write in the same falling-edge slot.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NSRC    = 8;
  localparam int ADDR_W  = 2;
  localparam int VEC_W   = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_FLAGS = 2'd0,
    REG_MASK  = 2'd1,
    REG_CTRL  = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;

  // bit of the control register that enables software posting
  localparam int SWEN_BIT = 7;
endpackage

// File: rtl/pic_edge_detect.sv
// Turns raw source inputs into one-cycle set requests. Bits selected by
// EDGE_SRC fire on a rising edge; the others pass their level through.
module pic_edge_detect #(
  parameter int          N        = 8,
  parameter logic [N-1:0] EDGE_SRC = 8'h90
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_in,
  output logic [N-1:0] set_req
);
  for (genvar i = 0; i < N; i++) begin : g_src
    if (EDGE_SRC[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= raw_in[i];
      end
      assign set_req[i] = raw_in[i] & ~prev_q;

      // R5: an edge request can never last two cycles in a row
      a_r5_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        set_req[i] |=> !set_req[i]);
    end else begin : g_level
      assign set_req[i] = raw_in[i];
    end
  end
endmodule

// File: rtl/pic_flags.sv
// Posted-flag register: hardware set, software post/clear, acknowledge clear.
module pic_flags #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hw_set,
  input  logic         wr_en,
  input  logic [N-1:0] wdata,
  input  logic         sw_en,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] sw_post, sw_clr, flags_d;

  always_comb begin
    sw_post = (wr_en && sw_en) ? wdata : '0;
    sw_clr  = wr_en ? ~wdata : '0;
    // hardware set dominates every clear source
    flags_d = hw_set | sw_post | (flags & ~(sw_clr | ack_clr));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R10 / R9: a hardware event always leaves the flag set
    a_r10_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set[i] |=> flags[i]);
    // R4: without the software enable and without hardware, a clear flag stays clear
    a_r4_no_post: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[i] && !hw_set[i] && !sw_en) |=> !flags[i]);
    // R3: writing 0 clears unless hardware fires
    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wdata[i] && !hw_set[i]) |=> !flags[i]);
    // R9: acknowledge clears unless hardware fires
    a_r9_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_clr[i] && !hw_set[i]) |=> !flags[i]);
  end
endmodule

// File: rtl/pic_prio.sv
// Lowest-index priority pick and vector generation.
module pic_prio #(
  parameter int               N         = 8,
  parameter int               VW        = 8,
  parameter logic [VW-1:0]    VEC_BASE  = 8'h04,
  parameter int               VEC_STEP  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  flags,
  input  logic [N-1:0]  mask,
  input  logic          gie,
  output logic [N-1:0]  grant,
  output logic          req,
  output logic [VW-1:0] vec
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  pend;
  logic [IW-1:0] idx;
  logic          any;

  always_comb begin
    pend  = flags & mask;
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
    if (any) grant[idx] = 1'b1;
    req = gie && any;
    vec = req ? VEC_BASE + VW'(idx) * VW'(VEC_STEP) : '0;
  end

  // R8: at most one source is granted
  a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R8: vectors sit on four-byte table slots
  a_r8_vec_align: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (vec[1:0] == 2'b00 && vec >= VEC_BASE));
  // R7: no request while the global enable is low
  a_r7_gie_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !req);
endmodule

// File: rtl/pic_vector_ctrl.sv
module pic_vector_ctrl
  import pic_pkg::*;
#(
  parameter logic [NSRC-1:0] EDGE_SRC = 8'h90,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h04,
  parameter int               VEC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_in,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [NSRC-1:0]   reg_wdata,
  output logic [NSRC-1:0]   reg_rdata,
  input  logic              gie,
  output logic              irq_req,
  input  logic              irq_ack,
  output logic [VEC_W-1:0]  irq_vec
);
  logic [NSRC-1:0] hw_set, flags, mask_q, grant, ack_clr;
  logic            swen_q;
  logic            wr_flags, wr_mask, wr_ctrl;

  assign wr_flags = reg_wr && (reg_addr == REG_FLAGS);
  assign wr_mask  = reg_wr && (reg_addr == REG_MASK);
  assign wr_ctrl  = reg_wr && (reg_addr == REG_CTRL);

  pic_edge_detect #(.N(NSRC), .EDGE_SRC(EDGE_SRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .raw_in(src_in), .set_req(hw_set));

  pic_flags #(.N(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .wr_en(wr_flags),
    .wdata(reg_wdata), .sw_en(swen_q), .ack_clr(ack_clr), .flags(flags));

  pic_prio #(.N(NSRC), .VW(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_prio (
    .clk(clk), .rst_n(rst_n), .flags(flags), .mask(mask_q), .gie(gie),
    .grant(grant), .req(irq_req), .vec(irq_vec));

  assign ack_clr = (irq_req && irq_ack) ? grant : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      swen_q <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= reg_wdata;
      if (wr_ctrl) swen_q <= reg_wdata[SWEN_BIT];
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel_e'(reg_addr))
      REG_FLAGS: reg_rdata = flags;
      REG_MASK:  reg_rdata = mask_q;
      REG_CTRL:  reg_rdata[SWEN_BIT] = swen_q;
      default:   reg_rdata = '0;
    endcase
  end

  // R7: a request always has a masked-in posted source behind it
  a_r7_req_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((flags & mask_q) != '0));
  // R11: the mask register holds between writes
  a_r11_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q));
endmodule

// File: tb/sim_pic_vector_ctrl.sv
module sim_pic_vector_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_in = '0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       gie = 1'b0;
  logic       irq_req;
  logic       irq_ack = 1'b0;
  logic [7:0] irq_vec;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pic_vector_ctrl u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_chk(string req, logic [1:0] a, logic [7:0] exp);
    reg_addr = a;
    #0.1;
    check(req, reg_rdata, exp);
  endtask

  task automatic pulse_src(logic [7:0] m);
    @(negedge clk);
    src_in = src_in | m;
    @(negedge clk);
    src_in = src_in & ~m;
  endtask

  task automatic clear_all();
    bus_write(2'd2, 8'h00);
    bus_write(2'd0, 8'h00);
    bus_write(2'd1, 8'h00);
  endtask

  task automatic t_reset();
    read_chk("R1 flags", 2'd0, 8'h00);
    read_chk("R1 mask", 2'd1, 8'h00);
    read_chk("R1 ctrl", 2'd2, 8'h00);
    check("R1 req", irq_req, 1'b0);
  endtask

  task automatic t_software();
    bus_write(2'd0, 8'hFF);
    read_chk("R4 post without enable", 2'd0, 8'h00);
    bus_write(2'd2, 8'h80);
    read_chk("R11 ctrl readback", 2'd2, 8'h80);
    bus_write(2'd1, 8'h5A);
    read_chk("R11 mask readback", 2'd1, 8'h5A);
    bus_write(2'd1, 8'h00);
    bus_write(2'd0, 8'h05);
    read_chk("R4 R2 sw post", 2'd0, 8'h05);
    bus_write(2'd2, 8'h00);
    bus_write(2'd0, 8'hFB);
    read_chk("R3 clear bit 2", 2'd0, 8'h01);
    bus_write(2'd0, 8'h00);
    read_chk("R3 clear all", 2'd0, 8'h00);
  endtask

  task automatic t_unmask();
    gie = 1'b1;
    pulse_src(8'h02);
    read_chk("R6 level source", 2'd0, 8'h02);
    check("R7 masked no req", irq_req, 1'b0);
    bus_write(2'd1, 8'h02);
    check("R7 unmask raises req", irq_req, 1'b1);
    check("R8 vec src1", irq_vec, 8'h08);
    clear_all();
    check("R8 vec zero idle", irq_vec, 8'h00);
  endtask

  task automatic t_gie();
    gie = 1'b0;
    bus_write(2'd1, 8'h0F);
    pulse_src(8'h08);
    check("R7 gie low", irq_req, 1'b0);
    gie = 1'b1;
    #0.1;
    check("R7 gie rise", irq_req, 1'b1);
    check("R8 vec src3", irq_vec, 8'h10);
    clear_all();
  endtask

  task automatic t_priority();
    gie = 1'b1;
    bus_write(2'd1, 8'hFF);
    pulse_src(8'h28);
    check("R8 lowest wins", irq_vec, 8'h10);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    read_chk("R9 ack clears vectored", 2'd0, 8'h20);
    check("R8 next vec src5", irq_vec, 8'h18);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    check("R9 req drops", irq_req, 1'b0);
    pulse_src(8'h01);
    check("R8 vec src0", irq_vec, 8'h04);
    clear_all();
  endtask

  task automatic t_edge();
    @(negedge clk); src_in[4] = 1'b1;
    @(negedge clk);
    read_chk("R5 rising edge posts", 2'd0, 8'h10);
    bus_write(2'd0, 8'h00);
    repeat (3) @(negedge clk);
    read_chk("R5 held level no repost", 2'd0, 8'h00);
    src_in[4] = 1'b0;
    @(negedge clk); src_in[7] = 1'b1;
    @(negedge clk); src_in[7] = 1'b0;
    read_chk("R5 port1 edge", 2'd0, 8'h80);
    clear_all();
  endtask

  task automatic t_races();
    // clear write and hw event on bit 1
    bus_write(2'd2, 8'h00);
    @(negedge clk);
    reg_addr = 2'd0; reg_wdata = 8'h00; reg_wr = 1'b1; src_in[1] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; src_in[1] = 1'b0;
    read_chk("R10 hw beats clear", 2'd0, 8'h02);
    clear_all();
    // sw post and hw event on bit 6
    bus_write(2'd2, 8'h80);
    @(negedge clk);
    reg_addr = 2'd0; reg_wdata = 8'h40; reg_wr = 1'b1; src_in[6] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; src_in[6] = 1'b0;
    read_chk("R10 post plus hw", 2'd0, 8'h40);
    clear_all();
    // ack and hw event on bit 0
    gie = 1'b1;
    bus_write(2'd1, 8'h01);
    pulse_src(8'h01);
    @(negedge clk); irq_ack = 1'b1; src_in[0] = 1'b1;
    @(negedge clk); irq_ack = 1'b0; src_in[0] = 1'b0;
    read_chk("R9 hw beats ack", 2'd0, 8'h01);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_software();
    t_unmask();
    t_gie();
    t_priority();
    t_edge();
    t_races();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule